// File: doc/BRIEF.md
# Configurable Asynchronous Character Receiver

This block takes a single start-stop serial line and turns each received character into a parallel word. The line is brought into the clock domain through a short synchronizer. It is then timed by a bit-rate counter that advances only on the cycles where an operation-clock enable is high. The counter samples the line in the middle of every bit. Character length, parity handling, bit order and line polarity are run-time inputs. They are expected to stay constant while a character is being received.

A finished character is written right-aligned into a 9-bit data register, and a one-cycle done pulse is raised with it. Stop-bit, parity and overrun problems each set a sticky flag, and a one-cycle error pulse is raised alongside the done pulse. The host acknowledges each character with a read strobe, which is how an overrun is detected. A clear input drops the three sticky flags.

Top module: `async_char_rx`

## Requirements
- R1: After reset, `rx_data` is zero and `done_pulse`, `err_pulse`, `frame_err`, `parity_err` and `overrun_err` are all low.
- R2: With divider value N (N ≥ 2), one bit lasts 2·(N+1) enable ticks. A low level is taken as a start bit only if it is still low at the middle of that bit; otherwise the receiver returns to idle silently, with no done pulse and no flag. With the enable high every cycle, count rising edges from 0 at the first edge after the line falls. For a frame of B bits in total (start, data, optional parity, stop), `done_pulse` is registered on edge 3 + N + (B−1)·2·(N+1).
- R3: `char_len` selects the data bits: 2'b00 gives 7, 2'b01 gives 8, 2'b10 or 2'b11 gives 9. `rx_data` is right-aligned and its unused upper bits are zero.
- R4: With `msb_first` = 0, the first data bit received lands in `rx_data[0]`. With `msb_first` = 1, it lands in bit (length − 1).
- R5: `par_mode` 2'b00 means there is no parity bit. 2'b01 means a parity bit is present but never checked. 2'b10 checks even parity and 2'b11 checks odd parity, counted over the data bits plus the parity bit. `parity_err` is set only by a mismatch in modes 2'b10 and 2'b11.
- R6: A stop bit sampled low sets `frame_err`. The character is still delivered.
- R7: A character that completes with no `rd_strobe` since the previous completion sets `overrun_err`, and the new character replaces the old one in `rx_data`. A read in between prevents the overrun.
- R8: With `line_inv` = 1, the line is complemented before decoding: the idle level is low and every bit is inverted.
- R9: `done_pulse` is high for exactly one cycle per character. `err_pulse` is high in that same cycle exactly when the character set any of the three error conditions.
- R10: The flags stay set until `flag_clr` is high. If a clear and a new error fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_en | input | 1 | Operation-clock enable tick that drives bit timing |
| rx_line | input | 1 | Serial input line |
| div_n | input | DIV_W (7) | Bit-rate divider value N, at least 2 |
| char_len | input | 2 | Data length select |
| par_mode | input | 2 | Parity mode select |
| msb_first | input | 1 | 1: most significant bit arrives first |
| line_inv | input | 1 | 1: line is inverted, idle low |
| rd_strobe | input | 1 | Host has taken the current character |
| flag_clr | input | 1 | Clears the three sticky error flags |
| rx_data | output | 9 | Last received character, right-aligned |
| done_pulse | output | 1 | One-cycle transfer-end pulse |
| err_pulse | output | 1 | One-cycle pulse for a character with an error |
| frame_err | output | 1 | Sticky stop-bit error flag |
| parity_err | output | 1 | Sticky parity error flag |
| overrun_err | output | 1 | Sticky overrun flag |

## Verification
A flag clear from the host can land in the same cycle as the completion of a character that carries an error. Both act on the same sticky flag register. The bench provokes this by holding `flag_clr` high for the whole of a frame that has a deliberately wrong parity bit. It then requires `parity_err` to read high in the cycle of the done pulse and low one cycle later, once the still-active clear has taken effect.

// File: rtl/acr_pkg.sv
package acr_pkg;

    localparam int CHAR_MAX = 9;
    localparam int IDX_W    = $clog2(CHAR_MAX + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    // Number of data bits for a length code.
    function automatic logic [IDX_W-1:0] char_bits(input logic [1:0] code);
        logic [IDX_W-1:0] n;
        case (code)
            2'b00:   n = IDX_W'(7);
            2'b01:   n = IDX_W'(8);
            default: n = IDX_W'(9);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/acr_line_sync.sv
module acr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic invert,
    output logic line_o
);
    logic [STAGES-1:0] sync_d, sync_q;
    logic              level;

    // Polarity is corrected before the chain so reset matches the idle level.
    assign level = line_in ^ invert;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sync_d = level;
        end else begin : g_many
            always_comb sync_d = {sync_q[STAGES-2:0], level};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign line_o = sync_q[STAGES-1];
endmodule

// File: rtl/acr_bit_timer.sv
module acr_bit_timer #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_en,
    input  logic             active,
    input  logic             half_sel,
    input  logic [DIV_W-1:0] div_n,
    output logic             sample_o
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] target;

    always_comb begin
        // Half bit: N+1 ticks; full bit: 2N+2 ticks.
        target   = half_sel ? {1'b0, div_n} : {div_n, 1'b1};
        cnt_d    = cnt_q;
        sample_o = 1'b0;
        if (!active) begin
            cnt_d = '0;
        end else if (op_en) begin
            if (cnt_q == target) begin
                sample_o = 1'b1;
                cnt_d    = '0;
            end else begin
                cnt_d = cnt_q + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/acr_frame_fsm.sv
module acr_frame_fsm
    import acr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_en,
    input  logic                line_b,
    input  logic                sample_i,
    input  logic [1:0]          char_len,
    input  logic [1:0]          par_mode,
    input  logic                msb_first,
    output logic                active_o,
    output logic                half_sel_o,
    output logic                fin_o,
    output logic [CHAR_MAX-1:0] fin_data,
    output logic                fin_perr,
    output logic                fin_ferr
);
    typedef struct packed {
        rx_state_e           st;
        logic [IDX_W-1:0]    idx;
        logic [CHAR_MAX-1:0] shreg;
        logic                par_acc;
        logic                perr;
    } fsm_t;

    fsm_t             fsm_d, fsm_q;
    logic [IDX_W-1:0] nbits;
    logic [IDX_W-1:0] pos;

    always_comb begin
        fsm_d    = fsm_q;
        fin_o    = 1'b0;
        fin_ferr = 1'b0;
        nbits    = char_bits(char_len);
        pos      = msb_first ? (nbits - IDX_W'(1) - fsm_q.idx) : fsm_q.idx;

        case (fsm_q.st)
            ST_IDLE: begin
                if (op_en && !line_b) begin
                    fsm_d.st      = ST_START;
                    fsm_d.idx     = '0;
                    fsm_d.shreg   = '0;
                    fsm_d.par_acc = 1'b0;
                    fsm_d.perr    = 1'b0;
                end
            end
            ST_START: begin
                if (sample_i) begin
                    // A start bit must still be low at its middle.
                    fsm_d.st = line_b ? ST_IDLE : ST_DATA;
                end
            end
            ST_DATA: begin
                if (sample_i) begin
                    for (int i = 0; i < CHAR_MAX; i++) begin
                        if (IDX_W'(i) == pos) fsm_d.shreg[i] = line_b;
                    end
                    fsm_d.par_acc = fsm_q.par_acc ^ line_b;
                    fsm_d.idx     = fsm_q.idx + IDX_W'(1);
                    if (fsm_q.idx == nbits - IDX_W'(1)) begin
                        fsm_d.st = (par_mode != 2'b00) ? ST_PAR : ST_STOP;
                    end
                end
            end
            ST_PAR: begin
                if (sample_i) begin
                    // Even (10): error if total odd. Odd (11): error if total even.
                    fsm_d.perr = par_mode[1] & (fsm_q.par_acc ^ line_b ^ par_mode[0]);
                    fsm_d.st   = ST_STOP;
                end
            end
            ST_STOP: begin
                if (sample_i) begin
                    fin_o    = 1'b1;
                    fin_ferr = ~line_b;
                    fsm_d.st = ST_IDLE;
                end
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st      <= ST_IDLE;
            fsm_q.idx     <= '0;
            fsm_q.shreg   <= '0;
            fsm_q.par_acc <= 1'b0;
            fsm_q.perr    <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign active_o   = (fsm_q.st != ST_IDLE);
    assign half_sel_o = (fsm_q.st == ST_START);
    assign fin_data   = fsm_q.shreg;
    assign fin_perr   = fsm_q.perr;
endmodule

// File: rtl/acr_result_reg.sv
module acr_result_reg
    import acr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fin_i,
    input  logic [CHAR_MAX-1:0] fin_data,
    input  logic                fin_perr,
    input  logic                fin_ferr,
    input  logic                rd_strobe,
    input  logic                flag_clr,
    output logic [CHAR_MAX-1:0] rx_data,
    output logic                done_pulse,
    output logic                err_pulse,
    output logic                frame_err,
    output logic                parity_err,
    output logic                overrun_err
);
    typedef struct packed {
        logic [CHAR_MAX-1:0] data;
        logic                done;
        logic                err;
        logic                fe;
        logic                pe;
        logic                oe;
        logic                unread;
    } res_t;

    res_t res_d, res_q;
    logic ovr;

    always_comb begin
        res_d      = res_q;
        res_d.done = 1'b0;
        res_d.err  = 1'b0;
        ovr        = res_q.unread & ~rd_strobe;
        if (flag_clr) begin
            res_d.fe = 1'b0;
            res_d.pe = 1'b0;
            res_d.oe = 1'b0;
        end
        if (rd_strobe) res_d.unread = 1'b0;
        // Completion comes after the clear, so a new error wins.
        if (fin_i) begin
            res_d.data   = fin_data;
            res_d.done   = 1'b1;
            res_d.err    = fin_perr | fin_ferr | ovr;
            res_d.unread = 1'b1;
            if (fin_ferr) res_d.fe = 1'b1;
            if (fin_perr) res_d.pe = 1'b1;
            if (ovr)      res_d.oe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign rx_data     = res_q.data;
    assign done_pulse  = res_q.done;
    assign err_pulse   = res_q.err;
    assign frame_err   = res_q.fe;
    assign parity_err  = res_q.pe;
    assign overrun_err = res_q.oe;
endmodule

// File: rtl/async_char_rx.sv
module async_char_rx
    import acr_pkg::*;
#(
    parameter int DIV_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_en,
    input  logic                rx_line,
    input  logic [DIV_W-1:0]    div_n,
    input  logic [1:0]          char_len,
    input  logic [1:0]          par_mode,
    input  logic                msb_first,
    input  logic                line_inv,
    input  logic                rd_strobe,
    input  logic                flag_clr,
    output logic [CHAR_MAX-1:0] rx_data,
    output logic                done_pulse,
    output logic                err_pulse,
    output logic                frame_err,
    output logic                parity_err,
    output logic                overrun_err
);
    logic                line_b;
    logic                sample;
    logic                active;
    logic                half_sel;
    logic                fin;
    logic [CHAR_MAX-1:0] fin_data;
    logic                fin_perr;
    logic                fin_ferr;

    acr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (rx_line),
        .invert  (line_inv),
        .line_o  (line_b)
    );

    acr_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_en    (op_en),
        .active   (active),
        .half_sel (half_sel),
        .div_n    (div_n),
        .sample_o (sample)
    );

    acr_frame_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_en      (op_en),
        .line_b     (line_b),
        .sample_i   (sample),
        .char_len   (char_len),
        .par_mode   (par_mode),
        .msb_first  (msb_first),
        .active_o   (active),
        .half_sel_o (half_sel),
        .fin_o      (fin),
        .fin_data   (fin_data),
        .fin_perr   (fin_perr),
        .fin_ferr   (fin_ferr)
    );

    acr_result_reg u_res (
        .clk         (clk),
        .rst_n       (rst_n),
        .fin_i       (fin),
        .fin_data    (fin_data),
        .fin_perr    (fin_perr),
        .fin_ferr    (fin_ferr),
        .rd_strobe   (rd_strobe),
        .flag_clr    (flag_clr),
        .rx_data     (rx_data),
        .done_pulse  (done_pulse),
        .err_pulse   (err_pulse),
        .frame_err   (frame_err),
        .parity_err  (parity_err),
        .overrun_err (overrun_err)
    );
endmodule

// File: rtl/acr_chk.sv
module acr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       flag_clr,
    input logic [1:0] par_mode,
    input logic [1:0] char_len,
    input logic [8:0] rx_data,
    input logic       done_pulse,
    input logic       err_pulse,
    input logic       frame_err,
    input logic       parity_err,
    input logic       overrun_err
);
    a_r9_err_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> done_pulse);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    a_r10_parity_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (parity_err && !flag_clr) |=> parity_err);

    a_r10_frame_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_err && !flag_clr) |=> frame_err);

    a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> (done_pulse || !(parity_err || frame_err || overrun_err)));

    a_r5_unchecked_modes: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(parity_err) |-> par_mode[1]);

    a_r7_overrun_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_err) |-> (done_pulse && err_pulse));

    a_r3_seven_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (done_pulse && char_len == 2'b00) |-> (rx_data[8:7] == 2'b00));
endmodule

bind async_char_rx acr_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flag_clr    (flag_clr),
    .par_mode    (par_mode),
    .char_len    (char_len),
    .rx_data     (rx_data),
    .done_pulse  (done_pulse),
    .err_pulse   (err_pulse),
    .frame_err   (frame_err),
    .parity_err  (parity_err),
    .overrun_err (overrun_err)
);

// File: tb/sim_async_char_rx.sv
`timescale 1ns/1ps
module sim_async_char_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_en = 1'b0;
    logic       rx_in = 1'b1;
    logic [6:0] div_n = 7'd2;
    logic [1:0] char_len = 2'b01;
    logic [1:0] par_mode = 2'b00;
    logic       msb_first = 1'b0;
    logic       line_inv = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       flag_clr = 1'b0;
    logic [8:0] rx_data;
    logic       done_pulse, err_pulse, frame_err, parity_err, overrun_err;

    int checks = 0;
    int errors = 0;
    int en_div = 1;
    int en_cnt = 0;
    int cyc = 0;
    int fall_cyc = 0;
    int done_cyc = 0;
    logic       seen;
    logic [8:0] got_data;
    logic       got_err, got_pe, got_fe, got_oe;

    async_char_rx u0 (
        .clk(clk), .rst_n(rst_n), .op_en(op_en), .rx_line(rx_in),
        .div_n(div_n), .char_len(char_len), .par_mode(par_mode),
        .msb_first(msb_first), .line_inv(line_inv), .rd_strobe(rd_strobe),
        .flag_clr(flag_clr), .rx_data(rx_data), .done_pulse(done_pulse),
        .err_pulse(err_pulse), .frame_err(frame_err), .parity_err(parity_err),
        .overrun_err(overrun_err)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        forever begin
            @(negedge clk);
            en_cnt = (en_cnt + 1 >= en_div) ? 0 : en_cnt + 1;
            op_en  = (en_cnt == 0);
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int bit_cyc();
        return 2 * (int'(div_n) + 1) * en_div;
    endfunction

    task automatic send_char(input logic [8:0] val, input int nb,
                             input logic bad_par, input logic stop_lvl);
        logic bits [0:11];
        logic [8:0] vm;
        logic p;
        int n;
        vm = val & ((9'h1 << nb) - 9'h1);
        bits[0] = 1'b0;
        for (int i = 0; i < nb; i++) bits[1+i] = msb_first ? vm[nb-1-i] : vm[i];
        n = 1 + nb;
        if (par_mode != 2'b00) begin
            p = (par_mode == 2'b10) ? ^vm : (par_mode == 2'b11) ? ~^vm : 1'b0;
            bits[n] = p ^ bad_par;
            n++;
        end
        bits[n] = stop_lvl;
        n++;
        for (int j = 0; j < n; j++) begin
            for (int k = 0; k < bit_cyc(); k++) begin
                @(negedge clk);
                if (j == 0 && k == 0) fall_cyc = cyc;
                rx_in = bits[j] ^ line_inv;
            end
        end
        @(negedge clk);
        rx_in = ~line_inv;
    endtask

    task automatic wait_done(input int limit);
        seen = 1'b0;
        for (int c = 0; c < limit && !seen; c++) begin
            @(negedge clk);
            if (done_pulse) begin
                seen     = 1'b1;
                got_data = rx_data;
                got_err  = err_pulse;
                got_pe   = parity_err;
                got_fe   = frame_err;
                got_oe   = overrun_err;
                done_cyc = cyc;
            end
        end
    endtask

    task automatic rx_one(input logic [8:0] val, input int nb,
                          input logic bad_par, input logic stop_lvl);
        fork
            send_char(val, nb, bad_par, stop_lvl);
            wait_done(40 * bit_cyc());
        join
        repeat (4) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "rx_data", 32'(rx_data), 32'h0);
        chk("R1", "flags+pulses",
            {27'b0, done_pulse, err_pulse, frame_err, parity_err, overrun_err}, 32'h0);
    endtask

    task automatic t_basic_timing();
        int b;
        char_len = 2'b01; par_mode = 2'b00; msb_first = 1'b0;
        rx_one(9'h0A5, 8, 1'b0, 1'b1);
        chk("R3", "8-bit lsb data", 32'(got_data), 32'h0A5);
        chk("R9", "done seen", 32'(seen), 32'h1);
        chk("R9", "no err pulse on clean char", 32'(got_err), 32'h0);
        b = 10;
        chk("R2", "done edge count", 32'(done_cyc - fall_cyc),
            32'(4 + int'(div_n) + (b - 1) * 2 * (int'(div_n) + 1)));
        chk("R9", "done low afterwards", 32'(done_pulse), 32'h0);
        do_read();
    endtask

    task automatic t_len7_msb_even();
        char_len = 2'b00; par_mode = 2'b10; msb_first = 1'b1;
        rx_one(9'h05B, 7, 1'b0, 1'b1);
        chk("R4", "7-bit msb-first data", 32'(got_data), 32'h05B);
        chk("R5", "even parity ok", 32'(got_pe), 32'h0);
        do_read();
    endtask

    task automatic t_len9_odd();
        char_len = 2'b10; par_mode = 2'b11; msb_first = 1'b0;
        rx_one(9'h1C3, 9, 1'b0, 1'b1);
        chk("R3", "9-bit data", 32'(got_data), 32'h1C3);
        chk("R5", "odd parity ok", 32'(got_pe), 32'h0);
        do_read();
        msb_first = 1'b1;
        rx_one(9'h10E, 9, 1'b0, 1'b1);
        chk("R4", "9-bit msb-first data", 32'(got_data), 32'h10E);
        do_read();
    endtask

    task automatic t_parity_err();
        char_len = 2'b01; par_mode = 2'b10; msb_first = 1'b0;
        rx_one(9'h033, 8, 1'b1, 1'b1);
        chk("R5", "even mismatch flagged", 32'(got_pe), 32'h1);
        chk("R9", "err pulse with done", 32'(got_err), 32'h1);
        chk("R10", "parity flag sticky", 32'(parity_err), 32'h1);
        do_read();
        do_clear();
        chk("R10", "clear drops parity flag", 32'(parity_err), 32'h0);
    endtask

    task automatic t_zero_par();
        char_len = 2'b01; par_mode = 2'b01;
        rx_one(9'h0F0, 8, 1'b1, 1'b1);
        chk("R5", "zero parity unchecked", 32'({got_pe, got_err}), 32'h0);
        chk("R5", "zero parity data", 32'(got_data), 32'h0F0);
        do_read();
        par_mode = 2'b00;
    endtask

    task automatic t_frame_err();
        char_len = 2'b01; par_mode = 2'b00;
        rx_one(9'h03C, 8, 1'b0, 1'b0);
        chk("R6", "low stop flagged", 32'(got_fe), 32'h1);
        chk("R6", "char still delivered", 32'(got_data), 32'h03C);
        chk("R9", "err pulse on frame error", 32'(got_err), 32'h1);
        do_read();
        do_clear();
        chk("R10", "clear drops frame flag", 32'(frame_err), 32'h0);
    endtask

    task automatic t_invert();
        @(negedge clk);
        line_inv = 1'b1; rx_in = 1'b0;
        repeat (10) @(negedge clk);
        char_len = 2'b01; par_mode = 2'b10; msb_first = 1'b0;
        rx_one(9'h096, 8, 1'b0, 1'b1);
        chk("R8", "inverted line data", 32'(got_data), 32'h096);
        chk("R8", "inverted line no error", 32'(got_err), 32'h0);
        do_read();
        @(negedge clk);
        line_inv = 1'b0; rx_in = 1'b1;
        par_mode = 2'b00;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_overrun();
        char_len = 2'b01;
        rx_one(9'h011, 8, 1'b0, 1'b1);
        chk("R7", "first char no overrun", 32'(got_oe), 32'h0);
        rx_one(9'h022, 8, 1'b0, 1'b1);
        chk("R7", "unread char overruns", 32'(got_oe), 32'h1);
        chk("R7", "newest data kept", 32'(got_data), 32'h022);
        chk("R9", "err pulse on overrun", 32'(got_err), 32'h1);
        do_read();
        do_clear();
        rx_one(9'h044, 8, 1'b0, 1'b1);
        chk("R7", "read prevents overrun", 32'(got_oe), 32'h0);
        do_read();
    endtask

    task automatic t_glitch();
        int pulses = 0;
        @(negedge clk) rx_in = 1'b0;
        @(negedge clk);
        @(negedge clk) rx_in = 1'b1;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (done_pulse || err_pulse) pulses++;
        end
        chk("R2", "short low rejected", 32'(pulses), 32'h0);
        chk("R2", "no flag after reject",
            32'({frame_err, parity_err, overrun_err}), 32'h0);
    endtask

    task automatic t_slow();
        en_div = 3; div_n = 7'd5;
        repeat (6) @(negedge clk);
        char_len = 2'b01; par_mode = 2'b11; msb_first = 1'b1;
        rx_one(9'h0C9, 8, 1'b0, 1'b1);
        chk("R2", "slow rate data", 32'(got_data), 32'h0C9);
        chk("R2", "slow rate no error", 32'(got_err), 32'h0);
        do_read();
        en_div = 1; div_n = 7'd2; par_mode = 2'b00; msb_first = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_set_wins();
        char_len = 2'b01; par_mode = 2'b11;
        @(negedge clk) flag_clr = 1'b1;
        rx_one(9'h05A, 8, 1'b1, 1'b1);
        // rx_one waited after done; re-run the check at the done cycle itself.
        flag_clr = 1'b1;
        fork
            send_char(9'h05A, 8, 1'b1, 1'b1);
            wait_done(40 * bit_cyc());
        join_any
        chk("R10", "set wins over clear", 32'(got_pe), 32'h1);
        @(negedge clk);
        chk("R10", "held clear drops flag next cycle", 32'(parity_err), 32'h0);
        wait fork;
        flag_clr = 1'b0;
        do_read();
        par_mode = 2'b00;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_basic_timing();
        t_len7_msb_even();
        t_len9_odd();
        t_parity_err();
        t_zero_par();
        t_frame_err();
        t_invert();
        t_overrun();
        t_glitch();
        t_slow();
        t_set_wins();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule